// File: doc/BRIEF.md
# Priority-Bid Interrupt Arbiter

This block is the interrupt controller of a four-channel serial device. Every channel offers four interrupt sources: receive data, transmit space, break and change of state. Two counter/timers add one source each. Each active source presents an 8-bit bid. The bid joins an urgency field (a live FIFO level or a host-programmed priority), a fixed kind code and a channel number. Because of this layout, a plain numeric comparison ranks the sources. The largest bid wins.

A free-running timer ends an arbitration every `EVAL_PERIOD` clocks. At that point the current winner is stored in a winner latch. The winner latch is shown inverted on an active-low interrupt bus. The interrupt request goes low only while the stored winner is numerically above a programmable threshold. An acknowledge pulse, or a write to the command address, copies the stored winner into the current-interrupt register. If that capture falls outside an evaluation cycle, the next evaluation is skipped, so the winner stays put while the host reads it. A small register file holds the threshold, the enables and the priorities, and it is read back through one combinational read port.

Top module: `irq_bid_arbiter`

## Requirements
- R1: A receiver bid is {fill count[2:0], error, 2'b11, channel[1:0]}. Channels a to d are numbered 0 to 3. A receiver makes no bid (value 0) when its count is zero or its enable bit (register 1, bits 3:0) is clear.
- R2: A transmitter bid is {1'b0, free slots[1:0], 3'b010, channel}. A transmitter with zero free slots, or with its enable bit (register 1, bits 7:4) clear, makes no bid.
- R3: Break, change-of-state and counter/timer bids are {priority[2:0], kind, channel}, with kind 3'b100, 3'b001 and 3'b101 respectively. The break priority is register 3 bits 2:0. The change-of-state priority is register 3 bits 5:3. The counter/timer priority is register 4 bits 2:0. Break and change-of-state enables are register 2 bits 3:0 and 7:4. The counter/timer enables are register 3 bit 6 (first timer, channel 01) and bit 7 (second timer, channel 11).
- R4: The numerically largest bid is stored in the winner latch on each arbitration strobe. Strobes come every `EVAL_PERIOD` clocks, the first one in the `EVAL_PERIOD`-th cycle after reset is released. `int_bus_n` is the bitwise inverse of the latch, so it reads FFh when nothing bids.
- R5: `irq_n` is low exactly when the stored winner is strictly greater than the threshold (register 0).
- R6: A capture in a strobe cycle loads the current-interrupt register with the winner stored before that strobe. The strobe still updates the latch.
- R7: A capture outside a strobe cycle loads the current-interrupt register and suppresses the next strobe, so the latch holds. The strobe after that resumes normal updates.
- R8: A write to address 5 is a capture command and behaves like the acknowledge in R6 and R7.
- R9: Registers 0 to 4 read back the values written to them (register 4 bits 7:3 read 0). Address 5 reads the current-interrupt register, address 6 reads the stored winner and address 7 reads 0.
- R10: After reset, every register, the winner latch and the current-interrupt register are 0, `int_bus_n` is FFh and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | 12 | Receive FIFO fill level, 3 bits per channel |
| rx_err | input | 4 | Receive error flag per channel (parity, framing or overrun) |
| tx_free | input | 8 | Free transmit FIFO slots, 2 bits per channel |
| brk_evt | input | 4 | Break condition pending, per channel |
| cos_evt | input | 4 | Change-of-state pending, per channel |
| ct_evt | input | 2 | Counter/timer event pending, one per timer |
| ack | input | 1 | Interrupt acknowledge pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| int_bus_n | output | 8 | Inverted stored winner (FFh means no source) |
| irq_n | output | 1 | Active-low interrupt request |
| arb_strobe | output | 1 | High in a cycle whose closing edge updates the winner latch |

## Verification
The bench goes after several corner cases. Two bids can differ only in the channel field: a design that mishandled the low bits would pick the wrong channel or toggle between the two. Fill levels of zero, full transmit FIFOs and masked sources must make no bid: a design that let them bid would raise an interrupt, or show a bus value other than FFh, with nothing pending. A bid equal to the threshold must not raise a request, so an off-by-one compare shows up at once. Acknowledges are placed both in and out of a strobe cycle: a design that skipped the suppression would let the latch move under the host, and one that captured after the strobe would report the new winner in place of the old one.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    localparam int NUM_CH   = 4;
    localparam int NUM_CT   = 2;
    localparam int CH_W     = 2;
    localparam int BID_W    = 8;
    localparam int CNT_W    = 3;
    localparam int FREE_W   = 2;
    localparam int PRI_W    = 3;
    localparam int ADDR_W   = 3;
    localparam int NUM_SRC  = 4 * NUM_CH + NUM_CT;

    typedef logic [BID_W-1:0] bid_t;

    // fixed kind codes placed in bid bits 4:2
    localparam logic [2:0] KIND_COS = 3'b001;
    localparam logic [2:0] KIND_TX  = 3'b010;
    localparam logic [2:0] KIND_RX  = 3'b011;
    localparam logic [2:0] KIND_BRK = 3'b100;
    localparam logic [2:0] KIND_CT  = 3'b101;
    localparam logic [2:0] KIND_RXE = 3'b111;

    typedef enum logic [ADDR_W-1:0] {
        RA_THRESH = 3'd0,
        RA_DMASK  = 3'd1,
        RA_EMASK  = 3'd2,
        RA_PRI_EV = 3'd3,
        RA_PRI_CT = 3'd4,
        RA_CMD    = 3'd5,
        RA_WIN    = 3'd6,
        RA_SPARE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [BID_W-1:0]  thresh;
        logic [NUM_CH-1:0] tx_en;
        logic [NUM_CH-1:0] rx_en;
        logic [NUM_CH-1:0] cos_en;
        logic [NUM_CH-1:0] brk_en;
        logic [NUM_CT-1:0] ct_en;
        logic [PRI_W-1:0]  cos_pri;
        logic [PRI_W-1:0]  brk_pri;
        logic [PRI_W-1:0]  ct_pri;
    } cfg_t;

    function automatic bid_t make_bid(input logic valid, input logic [2:0] hi,
                                      input logic [2:0] kind, input logic [CH_W-1:0] ch);
        return valid ? {hi, kind, ch} : '0;
    endfunction

    // timer 0 serves channels a/b, timer 1 serves c/d
    function automatic logic [CH_W-1:0] timer_chan(input int idx);
        return (idx == 0) ? 2'b01 : 2'b11;
    endfunction

endpackage

// File: rtl/bid_gen.sv
module bid_gen
    import irqa_pkg::*;
(
    input  cfg_t                              cfg,
    input  logic [NUM_CH*CNT_W-1:0]           rx_count,
    input  logic [NUM_CH-1:0]                 rx_err,
    input  logic [NUM_CH*FREE_W-1:0]          tx_free,
    input  logic [NUM_CH-1:0]                 brk_evt,
    input  logic [NUM_CH-1:0]                 cos_evt,
    input  logic [NUM_CT-1:0]                 ct_evt,
    output logic [NUM_SRC-1:0][BID_W-1:0]     bids
);

    localparam int TX_BASE  = NUM_CH;
    localparam int BRK_BASE = 2 * NUM_CH;
    localparam int COS_BASE = 3 * NUM_CH;
    localparam int CT_BASE  = 4 * NUM_CH;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CNT_W-1:0]  fill;
        logic [FREE_W-1:0] room;
        logic [2:0]        rx_kind;

        assign fill    = rx_count[c*CNT_W +: CNT_W];
        assign room    = tx_free[c*FREE_W +: FREE_W];
        assign rx_kind = rx_err[c] ? KIND_RXE : KIND_RX;

        assign bids[c]            = make_bid(cfg.rx_en[c] && (fill != '0), fill,
                                             rx_kind, CH_W'(c));
        assign bids[TX_BASE + c]  = make_bid(cfg.tx_en[c] && (room != '0), {1'b0, room},
                                             KIND_TX, CH_W'(c));
        assign bids[BRK_BASE + c] = make_bid(cfg.brk_en[c] && brk_evt[c], cfg.brk_pri,
                                             KIND_BRK, CH_W'(c));
        assign bids[COS_BASE + c] = make_bid(cfg.cos_en[c] && cos_evt[c], cfg.cos_pri,
                                             KIND_COS, CH_W'(c));
    end

    for (genvar k = 0; k < NUM_CT; k++) begin : g_ct
        assign bids[CT_BASE + k] = make_bid(cfg.ct_en[k] && ct_evt[k], cfg.ct_pri,
                                            KIND_CT, timer_chan(k));
    end

endmodule

// File: rtl/bid_max.sv
module bid_max
    import irqa_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0][BID_W-1:0]   bids,
    output bid_t                      best
);

    always_comb begin
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (bids[i] > best) best = bids[i];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R4: no bidder may exceed the chosen winner
        a_r4_max_bound: assert property (@(posedge clk) disable iff (rst)
            best >= bids[i]);
    end

endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cap_req,
    output logic strobe
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;
    logic          hold_q;
    logic          tick;

    assign tick   = (cnt_q == CW'(PERIOD - 1));
    assign strobe = tick && !hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + CW'(1);
            if (tick)
                hold_q <= 1'b0;
            else if (cap_req)
                hold_q <= 1'b1;
        end
    end

    // R7: a capture between ticks keeps the following cycle from strobing
    a_r7_capture_skips: assert property (@(posedge clk) disable iff (rst)
        (cap_req && !tick) |=> !strobe);

    // R4: strobes never fall in back-to-back cycles
    a_r4_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
    import irqa_pkg::*;
#(
    parameter int EVAL_PERIOD = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CH*CNT_W-1:0]      rx_count,
    input  logic [NUM_CH-1:0]            rx_err,
    input  logic [NUM_CH*FREE_W-1:0]     tx_free,
    input  logic [NUM_CH-1:0]            brk_evt,
    input  logic [NUM_CH-1:0]            cos_evt,
    input  logic [NUM_CT-1:0]            ct_evt,
    input  logic                         ack,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [BID_W-1:0]             wr_data,
    output logic [BID_W-1:0]             rd_data,
    output logic [BID_W-1:0]             int_bus_n,
    output logic                         irq_n,
    output logic                         arb_strobe
);

    cfg_t                          cfg_q;
    bid_t                          win_q;
    bid_t                          cir_q;
    bid_t                          best;
    logic [NUM_SRC-1:0][BID_W-1:0] bids;
    logic                          cap_req;

    assign cap_req = ack || (wr_en && (addr == RA_CMD));

    bid_gen u_bids (
        .cfg      (cfg_q),
        .rx_count (rx_count),
        .rx_err   (rx_err),
        .tx_free  (tx_free),
        .brk_evt  (brk_evt),
        .cos_evt  (cos_evt),
        .ct_evt   (ct_evt),
        .bids     (bids)
    );

    bid_max #(.N(NUM_SRC)) u_max (
        .clk  (clk),
        .rst  (rst),
        .bids (bids),
        .best (best)
    );

    arb_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cap_req (cap_req),
        .strobe  (arb_strobe)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_THRESH: cfg_q.thresh <= wr_data;
                RA_DMASK: begin
                    cfg_q.rx_en <= wr_data[3:0];
                    cfg_q.tx_en <= wr_data[7:4];
                end
                RA_EMASK: begin
                    cfg_q.brk_en <= wr_data[3:0];
                    cfg_q.cos_en <= wr_data[7:4];
                end
                RA_PRI_EV: begin
                    cfg_q.brk_pri <= wr_data[2:0];
                    cfg_q.cos_pri <= wr_data[5:3];
                    cfg_q.ct_en   <= wr_data[7:6];
                end
                RA_PRI_CT: cfg_q.ct_pri <= wr_data[2:0];
                default: ;
            endcase
        end
    end

    // winner latch and current-interrupt register
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cir_q <= '0;
        end else begin
            if (arb_strobe) win_q <= best;
            if (cap_req)    cir_q <= win_q;
        end
    end

    assign int_bus_n = ~win_q;
    assign irq_n     = !(win_q > cfg_q.thresh);

    always_comb begin
        case (addr)
            RA_THRESH: rd_data = cfg_q.thresh;
            RA_DMASK:  rd_data = {cfg_q.tx_en, cfg_q.rx_en};
            RA_EMASK:  rd_data = {cfg_q.cos_en, cfg_q.brk_en};
            RA_PRI_EV: rd_data = {cfg_q.ct_en, cfg_q.cos_pri, cfg_q.brk_pri};
            RA_PRI_CT: rd_data = {5'b0, cfg_q.ct_pri};
            RA_CMD:    rd_data = cir_q;
            RA_WIN:    rd_data = win_q;
            default:   rd_data = '0;
        endcase
    end

    // R4: the winner latch only moves on an arbitration strobe
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !arb_strobe |=> $stable(int_bus_n));

    // R5: a request needs a bidder on the bus
    a_r5_irq_needs_bid: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (int_bus_n != 8'hFF));

    // R6: a capture stores the winner held before the edge
    a_r6_cir_capture: assert property (@(posedge clk) disable iff (rst)
        cap_req |=> (cir_q == $past(~int_bus_n)));

endmodule

// File: tb/tb_irq_bid_arbiter.sv
module tb_irq_bid_arbiter;

    localparam int P = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] rx_count = '0;
    logic [3:0]  rx_err   = '0;
    logic [7:0]  tx_free  = '0;
    logic [3:0]  brk_evt  = '0;
    logic [3:0]  cos_evt  = '0;
    logic [1:0]  ct_evt   = '0;
    logic        ack      = 1'b0;
    logic        wr_en    = 1'b0;
    logic [2:0]  addr     = '0;
    logic [7:0]  wr_data  = '0;
    logic [7:0]  rd_data;
    logic [7:0]  int_bus_n;
    logic        irq_n;
    logic        arb_strobe;

    int checks = 0;
    int fails  = 0;

    // bench copies of the programmed registers
    logic [7:0] thr = '0, mdat = '0, mevt = '0, pra = '0, prb = '0;

    irq_bid_arbiter #(.EVAL_PERIOD(P)) dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .rx_err(rx_err),
        .tx_free(tx_free), .brk_evt(brk_evt), .cos_evt(cos_evt), .ct_evt(ct_evt),
        .ack(ack), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .int_bus_n(int_bus_n), .irq_n(irq_n),
        .arb_strobe(arb_strobe)
    );

    always #2 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        case (a)
            3'd0: thr  = d;
            3'd1: mdat = d;
            3'd2: mevt = d;
            3'd3: pra  = d;
            3'd4: prb  = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (3 * P) step();
    endtask

    task automatic clear_inputs();
        rx_count = '0; rx_err = '0; tx_free = '0;
        brk_evt = '0; cos_evt = '0; ct_evt = '0;
    endtask

    task automatic sync_strobe();
        while (arb_strobe !== 1'b1) step();
    endtask

    function automatic logic [7:0] model_win();
        logic [7:0] b, c;
        b = '0;
        for (int ch = 0; ch < 4; ch++) begin
            c = (mdat[ch] && rx_count[ch*3 +: 3] != 0) ?
                {rx_count[ch*3 +: 3], rx_err[ch], 2'b11, 2'(ch)} : 8'h00;
            if (c > b) b = c;
            c = (mdat[4+ch] && tx_free[ch*2 +: 2] != 0) ?
                {1'b0, tx_free[ch*2 +: 2], 3'b010, 2'(ch)} : 8'h00;
            if (c > b) b = c;
            c = (mevt[ch] && brk_evt[ch]) ? {pra[2:0], 3'b100, 2'(ch)} : 8'h00;
            if (c > b) b = c;
            c = (mevt[4+ch] && cos_evt[ch]) ? {pra[5:3], 3'b001, 2'(ch)} : 8'h00;
            if (c > b) b = c;
        end
        for (int k = 0; k < 2; k++) begin
            c = (pra[6+k] && ct_evt[k]) ? {prb[2:0], 3'b101, (k == 0) ? 2'b01 : 2'b11} : 8'h00;
            if (c > b) b = c;
        end
        return b;
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        chk("R10 bus idle", int_bus_n, 8'hFF);
        chk("R10 irq high", {7'b0, irq_n}, 8'h01);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R10 reg zero", v, 8'h00);
        end
        chk("R4 first cycle no strobe", {7'b0, arb_strobe}, 8'h00);
        step();
        chk("R4 strobe at period", {7'b0, arb_strobe}, 8'h01);
        step();
        chk("R4 strobe gap", {7'b0, arb_strobe}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd2, 8'h96);
        wr(3'd3, 8'hE9); wr(3'd4, 8'hFD); wr(3'd7, 8'hFF);
        rd(3'd0, v); chk("R9 thresh", v, 8'h5A);
        rd(3'd1, v); chk("R9 data mask", v, 8'hC3);
        rd(3'd2, v); chk("R9 event mask", v, 8'h96);
        rd(3'd3, v); chk("R9 event prio", v, 8'hE9);
        rd(3'd4, v); chk("R9 timer prio", v, 8'h05);
        rd(3'd7, v); chk("R9 spare", v, 8'h00);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    endtask

    task automatic t_rx();
        clear_inputs();
        wr(3'd1, 8'h0F);
        rx_count[2*3 +: 3] = 3'd5;
        settle(); chk("R1 rx ch2 count5", int_bus_n, ~8'hAE);
        rx_count[1*3 +: 3] = 3'd5; rx_err[1] = 1'b1;
        settle(); chk("R1 rx error ranks up", int_bus_n, ~8'hBD);
        rx_err[1] = 1'b0;
        settle(); chk("R1 channel tiebreak", int_bus_n, ~8'hAE);
        rx_count = '0;
        settle(); chk("R1 empty no bid", int_bus_n, 8'hFF);
        rx_count[3*3 +: 3] = 3'd7;
        wr(3'd1, 8'h07);
        settle(); chk("R1 masked no bid", int_bus_n, 8'hFF);
        clear_inputs();
    endtask

    task automatic t_tx();
        clear_inputs();
        wr(3'd1, 8'hF0);
        tx_free[1:0] = 2'd3;
        settle(); chk("R2 tx ch0 free3", int_bus_n, ~8'h68);
        tx_free[1:0] = 2'd0;
        settle(); chk("R2 full tx no bid", int_bus_n, 8'hFF);
        tx_free[1:0] = 2'd3; rx_count[2:0] = 3'd4;
        wr(3'd1, 8'hFF);
        settle(); chk("R2 rx half above empty tx", int_bus_n, ~8'h8C);
        clear_inputs();
        wr(3'd1, 8'h00);
    endtask

    task automatic t_evt();
        clear_inputs();
        wr(3'd2, 8'hFF); wr(3'd3, 8'hC0); wr(3'd4, 8'h00);
        brk_evt[3] = 1'b1; cos_evt[3] = 1'b1; ct_evt[0] = 1'b1;
        settle(); chk("R3 timer ab default top", int_bus_n, ~8'h15);
        ct_evt[0] = 1'b0;
        settle(); chk("R3 break over cos", int_bus_n, ~8'h13);
        brk_evt[3] = 1'b0;
        settle(); chk("R3 cos alone", int_bus_n, ~8'h07);
        cos_evt[3] = 1'b0; ct_evt[1] = 1'b1;
        settle(); chk("R3 timer cd channel", int_bus_n, ~8'h17);
        wr(3'd3, 8'hC7); brk_evt[3] = 1'b1;
        settle(); chk("R3 break prio 7", int_bus_n, ~8'hF3);
        clear_inputs();
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    endtask

    task automatic t_thresh();
        clear_inputs();
        wr(3'd1, 8'h0F);
        rx_count[2*3 +: 3] = 3'd5;
        wr(3'd0, 8'hAE);
        settle(); chk("R5 equal no irq", {7'b0, irq_n}, 8'h01);
        wr(3'd0, 8'hAD);
        settle(); chk("R5 above irq", {7'b0, irq_n}, 8'h00);
        clear_inputs(); wr(3'd0, 8'h00);
        settle(); chk("R5 no bid no irq", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_model();
        logic [31:0] x = 32'h1234_5679;
        logic [7:0]  exp;
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hD1); wr(3'd4, 8'h03);
        wr(3'd0, 8'h90);
        for (int it = 0; it < 24; it++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            rx_count = x[11:0]; rx_err = x[15:12]; tx_free = x[23:16];
            brk_evt = x[27:24] & x[3:0]; cos_evt = x[31:28] & x[7:4];
            ct_evt = x[13:12] & x[21:20];
            settle();
            exp = model_win();
            chk("R4 max search", int_bus_n, ~exp);
            chk("R5 threshold", {7'b0, irq_n}, {7'b0, !(exp > thr)});
        end
        clear_inputs();
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h00);
    endtask

    task automatic t_ack_eval();
        logic [7:0] v;
        clear_inputs(); wr(3'd1, 8'h0F);
        rx_count[2:0] = 3'd2;
        settle(); sync_strobe();
        rx_count[2:0] = 3'd6; ack = 1'b1;
        step(); ack = 1'b0;
        chk("R6 latch still updates", int_bus_n, ~8'hCC);
        rd(3'd5, v); chk("R6 cir keeps prior winner", v, 8'h4C);
    endtask

    task automatic t_capture_off(input logic use_cmd, input string tag);
        logic [7:0] v;
        clear_inputs(); wr(3'd1, 8'h0F);
        rx_count[2:0] = 3'd2;
        settle(); sync_strobe(); step();
        rx_count[2:0] = 3'd6;
        if (use_cmd) begin wr_en = 1'b1; addr = 3'd5; wr_data = 8'h00; end
        else ack = 1'b1;
        step();
        ack = 1'b0; wr_en = 1'b0;
        chk({tag, " strobe suppressed"}, {7'b0, arb_strobe}, 8'h00);
        step();
        chk({tag, " latch held"}, int_bus_n, ~8'h4C);
        rd(3'd5, v); chk({tag, " cir loaded"}, v, 8'h4C);
        step();
        chk({tag, " strobe resumes"}, {7'b0, arb_strobe}, 8'h01);
        step();
        chk({tag, " latch resumes"}, int_bus_n, ~8'hCC);
        clear_inputs();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_rx();
        t_tx();
        t_evt();
        t_thresh();
        t_model();
        t_ack_eval();
        t_capture_off(1'b0, "R7");
        t_capture_off(1'b1, "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule